// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block is a management-bus master for Ethernet PHYs. Software programs a clock divider and a preamble switch in a control word, then writes one 32-bit command word. The command word is laid out exactly as a Clause 22 management frame: start pattern, opcode, PHY address, register address, turnaround and 16 data bits. That single write launches the whole transaction. The block generates the management clock, optionally sends a preamble of ones, and shifts the command word out MSB-first. On reads it releases the data line for the turnaround and data phases, and it captures the PHY's 16-bit reply.

A busy flag in the control word stays set for the whole frame. Software polls it until it clears, then reads the captured value from the low half of the command register. The data line appears as three plain signals: an output value, an output enable and an input value. The pad itself sits outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register (offset 0x0) and the command register (offset 0x4) both read zero, the busy flag is 0, MDC is low and the MDIO output enable is low.
- R2: The control register holds the clock divider in bits 6:0 and the preamble enable in bit 7, and reads back what was written. Bit 8 is the read-only busy flag, so writes to it have no effect. Bits 31:9 read zero.
- R3: A write to offset 0x4 while the block is idle stores the word and starts a frame. The busy flag reads 1 in the next cycle.
- R4: During a frame, MDC starts low. It first rises divider+1 clocks after the launch and then has a period of exactly 2×(divider+1) system clocks.
- R5: With the preamble enabled, 32 ones are sent before the frame, for 64 MDC cycles in total. With it disabled, only the 32 frame bits are sent.
- R6: Frame bits go out from command bit 31 down to bit 0, one per MDC cycle. MDIO changes only when MDC falls and is stable while MDC is high.
- R7: When opcode bits 29:28 equal 2 (read), the output enable is low from the bit taken from command bit 16 through bit 0. MDIO input is sampled on the rising MDC edges of bits 15..0, MSB first, and the two turnaround bits are ignored. After busy clears, bits 15:0 of offset 0x4 hold the captured value and bits 31:16 keep the command.
- R8: For any other opcode (1 = write), the output enable stays high for every frame bit, and offset 0x4 keeps the written word unchanged.
- R9: Busy stays set for exactly N×2×(divider+1) cycles, where N is 32 or 64. Whenever busy is clear, MDC is low and the output enable is low.
- R10: A write to offset 0x4 while busy is set is ignored. It does not change the running frame, the register contents or the result, and it does not start a new frame.
- R11: A control-register write during a frame updates the register at once, but the running frame keeps the divider and preamble it latched at launch. The new values apply from the next launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Byte offset (0x0 control, 0x4 command) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two events can fall in the same cycle: a command-register write can arrive on the very clock edge at which a read frame completes. On that edge the captured data must land in the register while the new write is still refused, because busy is still set there. The bench provokes this by issuing the write in the last cycle in which busy reads 1. It then checks that the register holds the command with the PHY's reply, not the injected word, and that no second frame starts. A mid-frame control write is judged the same way: the bench checks the MDC period of the running frame against the old divider and the next frame against the new one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    OPC_RSVD0 = 2'd0,
    OPC_WRITE = 2'd1,
    OPC_READ  = 2'd2,
    OPC_RSVD3 = 2'd3
  } mdio_opc_e;

  // Number of MDC cycles in a frame, with or without the ones preamble.
  function automatic int unsigned frame_cycles(input logic pre, input int unsigned fw);
    return pre ? 2 * fw : fw;
  endfunction

  // The opcode field sits just below the start bit of the frame word.
  function automatic logic word_is_read(input logic [31:0] w);
    return mdio_opc_e'(w[29:28]) == OPC_READ;
  endfunction

  // System clocks per MDC period for a given divider setting.
  function automatic int unsigned mdc_period(input int unsigned div);
    return 2 * (div + 1);
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             half_end;

  assign half_end  = run && (cnt_q == div);
  assign rise_tick = half_end && !mdc;
  assign fall_tick = half_end && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (half_end) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  mdc_low_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [FRAME_W-1:0] word,
  input  logic               pre,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               active,
  output logic               rd_q,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data
);
  import mdio_pkg::*;

  localparam int unsigned IDX_W = $clog2(2 * FRAME_W);
  localparam int unsigned BIT_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] TA_LAST = IDX_W'(DATA_W);

  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] word_q;
  logic [DATA_W-1:0]  shreg_q;
  logic               in_pre;
  logic               capture;

  assign in_pre  = idx_q >= IDX_W'(FRAME_W);
  assign mdio_o  = active && (in_pre ? 1'b1 : word_q[idx_q[BIT_W-1:0]]);
  assign mdio_oe = active && !(rd_q && idx_q <= TA_LAST);
  assign capture = active && rd_q && rise_tick && (idx_q < TA_LAST);
  assign done    = active && fall_tick && (idx_q == '0);
  assign rd_data = shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      word_q  <= '0;
      shreg_q <= '0;
    end else if (launch) begin
      active  <= 1'b1;
      rd_q    <= word_is_read(word);
      idx_q   <= IDX_W'(frame_cycles(pre, FRAME_W) - 1);
      word_q  <= word;
      shreg_q <= '0;
    end else if (active) begin
      if (capture) shreg_q <= {shreg_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == '0) active <= 1'b0;
        else             idx_q  <= idx_q - 1'b1;
      end
    end
  end

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_q && idx_q < TA_LAST) |-> !mdio_oe);

  // R5
  preamble_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_pre) |-> (mdio_o && mdio_oe));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned REG_W   = 32,
  parameter int unsigned DIV_W   = 7,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CMD_OFS  = ADDR_W'(4);
  localparam int unsigned PRE_BIT  = DIV_W;
  localparam int unsigned BUSY_BIT = DIV_W + 1;

  logic [DIV_W-1:0]  div_q;
  logic              pre_q;
  logic [DIV_W-1:0]  run_div_q;
  logic [REG_W-1:0]  cmd_q;
  logic              ctrl_wr;
  logic              data_wr;
  logic              launch;
  logic              busy;
  logic              rd_q;
  logic              done;
  logic              rise_tick;
  logic              fall_tick;
  logic [DATA_W-1:0] rd_data;

  assign ctrl_wr = reg_valid && reg_write && (reg_addr == CTRL_OFS);
  assign data_wr = reg_valid && reg_write && (reg_addr == CMD_OFS);
  assign launch  = data_wr && !busy;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_OFS) begin
      reg_rdata[DIV_W-1:0] = div_q;
      reg_rdata[PRE_BIT]   = pre_q;
      reg_rdata[BUSY_BIT]  = busy;
    end else if (reg_addr == CMD_OFS) begin
      reg_rdata = cmd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      pre_q     <= 1'b0;
      run_div_q <= '0;
      cmd_q     <= '0;
    end else begin
      if (ctrl_wr) begin
        div_q <= reg_wdata[DIV_W-1:0];
        pre_q <= reg_wdata[PRE_BIT];
      end
      if (launch) begin
        cmd_q     <= reg_wdata;
        run_div_q <= div_q;
      end else if (done && rd_q) begin
        cmd_q[DATA_W-1:0] <= rd_data;
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .div       (run_div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine #(.FRAME_W(REG_W), .DATA_W(DATA_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .word      (reg_wdata),
    .pre       (pre_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (busy),
    .rd_q      (rd_q),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rd_data   (rd_data)
  );

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R3
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy && !done) |=> $stable(cmd_q));

  // R6
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R11
  divider_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch && $past(busy)) |-> $stable(run_div_q));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [1:0] op, input logic [4:0] phy,
                                          input logic [4:0] ra, input logic [15:0] d);
    return {1'b0, 1'b1, op, phy, ra, 2'b10, d};
  endfunction

  function automatic bit exp_bit(input logic [31:0] w, input int b);
    return (b >= 32) ? 1'b1 : w[b];
  endfunction

  function automatic bit exp_oe(input logic [31:0] w, input int b);
    return !(w[29:28] == 2'd2 && b <= 16);
  endfunction

  function automatic logic [31:0] exp_reg(input logic [31:0] w, input logic [15:0] phy);
    return (w[29:28] == 2'd2) ? {w[31:16], phy} : w;
  endfunction

  function automatic logic phy_drive(input int b, input logic [15:0] phy);
    return (b >= 0 && b < 16) ? phy[b] : 1'($urandom % 2);
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // inj: 0 none, 1 command write, 2 control write, issued at busy cycle inj_c
  task automatic run_frame(input bit pre, input int div, input logic [31:0] w,
                           input logic [15:0] phy, input int inj, input int inj_c,
                           input logic [31:0] inj_d);
    int n_bits = pre ? 64 : 32;
    int c = 0, k = 0, last_rise = -1, n_rise = 0;
    int bad_bits = 0, bad_oe = 0, bad_per = 0;
    bit pm = 1'b0, first_busy = 1'b0;
    logic [31:0] rv;
    string dreq = (w[29:28] == 2'd2) ? "R7" : "R8";
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 3'd4; reg_wdata = w;
    mdio_i = phy_drive(n_bits - 1, phy);
    forever begin
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0; reg_addr = 3'd0;
      #1;
      if (c == 0) first_busy = reg_rdata[8];
      if (!reg_rdata[8]) break;
      if (mdc && !pm) begin
        int b = n_bits - 1 - k;
        if (mdio_oe !== exp_oe(w, b)) bad_oe++;
        if (exp_oe(w, b) && mdio_o !== exp_bit(w, b)) bad_bits++;
        if (last_rise < 0 && c != div + 1) bad_per++;
        if (last_rise >= 0 && c - last_rise != 2 * (div + 1)) bad_per++;
        last_rise = c;
        n_rise++;
      end
      if (!mdc && pm) begin
        k++;
        mdio_i = phy_drive(n_bits - 1 - k, phy);
      end
      pm = mdc;
      if (inj != 0 && c == inj_c) begin
        reg_valid = 1'b1; reg_write = 1'b1;
        reg_addr = (inj == 1) ? 3'd4 : 3'd0; reg_wdata = inj_d;
      end
      c++;
      if (c > 20000) break;
    end
    chk(first_busy == 1'b1, "R3 busy after launch", 32'(first_busy), 32'd1);
    chk(bad_per == 0, "R4 MDC timing errors", bad_per, 0);
    chk(n_rise == n_bits, "R5 MDC cycles per frame", n_rise, n_bits);
    chk(bad_bits == 0, "R6 driven bit mismatches", bad_bits, 0);
    chk(bad_oe == 0, (w[29:28] == 2'd2) ? "R7 output enable" : "R8 output enable", bad_oe, 0);
    chk(c == n_bits * 2 * (div + 1), "R9 busy duration", c, n_bits * 2 * (div + 1));
    chk(!mdc && !mdio_oe, "R9 idle lines", {mdc, mdio_oe}, 0);
    bus_rd(3'd4, rv);
    chk(rv == exp_reg(w, phy), (inj == 1) ? "R10 register after ignored write" : dreq,
        rv, exp_reg(w, phy));
    bus_rd(3'd0, rv);
    chk(rv[8] == 1'b0, (inj == 1) ? "R10 no second frame" : "R9 busy clear", rv[8], 0);
    if (inj == 2) chk(rv == {23'd0, inj_d[8:0]} - {23'd0, inj_d[8], 8'd0},
                      "R11 control updated at once", rv, {24'd0, inj_d[7:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = 3'd0;
    reg_wdata = '0; mdio_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_rd(3'd0, rv); chk(rv == 32'd0, "R1 control reset", rv, 0);
    bus_rd(3'd4, rv); chk(rv == 32'd0, "R1 command reset", rv, 0);
    chk(!mdc && !mdio_oe, "R1 idle lines", {mdc, mdio_oe}, 0);
    // R2 readback, busy bit and upper bits not writable
    bus_wr(3'd0, 32'hFFFF_FF55);
    bus_rd(3'd0, rv); chk(rv == 32'h0000_0055, "R2 control readback", rv, 32'h55);
    bus_wr(3'd0, 32'h0000_011A);
    bus_rd(3'd0, rv); chk(rv == 32'h0000_001A, "R2 busy bit read-only", rv, 32'h1A);
    // Directed: fastest divider, no preamble, read
    bus_wr(3'd0, 32'h0000_0000);
    run_frame(1'b0, 0, mk_word(2'd2, 5'd3, 5'd1, 16'hFFFF), 16'hA5C3, 0, 0, 0);
    // Directed: typical divider with preamble, write
    bus_wr(3'd0, 32'h0000_009A);
    run_frame(1'b1, 26, mk_word(2'd1, 5'd31, 5'd17, 16'h1234), 16'h0, 0, 0, 0);
    // R10: command write in mid-frame
    bus_wr(3'd0, 32'h0000_0002);
    run_frame(1'b0, 2, mk_word(2'd2, 5'd1, 5'd2, 16'h0), 16'h5AA5, 1, 40, 32'h6FFF_0000);
    // R10: command write in the completion cycle of a read
    run_frame(1'b0, 2, mk_word(2'd2, 5'd9, 5'd4, 16'h0), 16'h0F0F, 1, 32 * 6 - 1,
              mk_word(2'd1, 5'd0, 5'd0, 16'hDEAD));
    // R11: control write mid-frame, then next frame uses new settings
    run_frame(1'b0, 2, mk_word(2'd1, 5'd7, 5'd7, 16'hBEEF), 16'h0, 2, 50, 32'h0000_0084);
    run_frame(1'b1, 4, mk_word(2'd2, 5'd7, 5'd7, 16'h0), 16'h8001, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 8; i++) begin
      int dv = $urandom % 6;
      bit pr = 1'($urandom % 2);
      logic [1:0] op = ($urandom % 2) ? 2'd1 : 2'd2;
      bus_wr(3'd0, {24'd0, pr, 7'(dv)});
      run_frame(pr, dv, mk_word(op, 5'($urandom), 5'($urandom), 16'($urandom)),
                16'($urandom), 0, 0, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule